// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side master for an 8-bit successive-approximation converter that is reached over a four-wire SPI link in mode 0 and runs its conversion from the serial clock. A client hands it one request at a time. Each request carries a 3-bit input select code, a polarity choice and a single-ended/differential choice. The block packs these into a command byte and lowers chip select. It then clocks out the command followed by two zero bytes, 24 serial clocks in all. From the 16 bits returned after the command it lifts the 8-bit result and hands it to the client. In unipolar mode the result is unsigned. In bipolar mode it is sign-extended two's complement.

When a request asks for continuous operation and the next request is already waiting, the next command byte takes the place of the tail of the current read, which gives 16 serial clocks per conversion inside one chip-select window. The serial clock half-period is a parameter counted in system clocks. A check at elaboration rejects any setting that puts the serial clock outside 50 kHz to 500 kHz, or that lets a transaction with its inter-byte gaps run past 1 ms. With such a setting, every request is refused with an error pulse and the link is never driven.

Both data interfaces are valid/ready. A request must stay stable while `req_valid_i` is high and is taken on a clock edge where `req_ready_o` is also high. A result stays on `res_data_o` with `res_valid_o` high until a clock edge where `res_ready_i` is high. Back-pressure on the result side stalls the serial link at the end of the first zero byte, with the serial clock parked low, so an unread result is never overwritten. The consumer must drain results fast enough to keep each conversion inside the 1 ms droop limit.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, res_valid_o is 0, err_o is 0 and req_ready_o is 1.
- R2: The command byte is sent MSB first on mosi_o as bit7 = 1, bits6:4 = req_sel_i, bit3 = 1 for unipolar / 0 for bipolar, bit2 = req_single_i, bits1:0 = 11.
- R3: sclk_o is low whenever cs_no is high, and mosi_o changes only while sclk_o is low.
- R4: A non-continuous request produces one chip-select low window with exactly 24 rising SCLK edges, and the second and third bytes on mosi_o are all zeros.
- R5: The result is the 8 MISO bits sampled on the 3rd to 10th rising edges after the command byte's last rising edge (bits 13:6 of the two following bytes), MSB first, placed in res_data_o[7:0].
- R6: res_data_o[8] equals res_data_o[7] for a bipolar request and is 0 for a unipolar request.
- R7: res_valid_o stays high with res_data_o unchanged until res_ready_i is high. While a result is unread, the link waits at the end of the first zero byte with chip select still low.
- R8: When the running request has req_cont_i = 1 and another request is waiting at the end of the first zero byte, that request's command byte follows at once in the same chip-select window (16 clocks per conversion). The last conversion gets a trailing zero byte.
- R9: Inside a byte every SCLK high phase and low phase lasts HALF_DIV system clocks.
- R10: With an illegal divider or timing budget, a request is accepted, err_o pulses high for one cycle, cs_no stays high and no result appears.
- R11: req_ready_o is high only while no result is unread and sclk_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted on this edge when valid is high |
| req_sel_i | input | 3 | Input select code for the command byte |
| req_bipolar_i | input | 1 | 1 = bipolar (signed) result, 0 = unipolar |
| req_single_i | input | 1 | 1 = single-ended, 0 = differential |
| req_cont_i | input | 1 | 1 = chain the next waiting request into the same window |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result consumed on this edge when valid is high |
| res_data_o | output | RES_W+1 | Result, sign-extended in bipolar mode |
| err_o | output | 1 | One-cycle pulse when a request is refused for illegal timing |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the converter |
| miso_i | input | 1 | Serial data from the converter |

## Verification
On every cycle the assertions check these rules: the serial clock stays parked while chip select is high, MOSI holds steady through each high phase, every high phase lasts exactly HALF_DIV cycles, a pending result holds still under back-pressure, the sign-extension bit never disagrees with a non-negative byte, errors occur only with chip select high, and requests are taken only with the clock low and the output empty. What only the bench scenarios can show is the content of the link: the command byte bits, the edge counts of single and chained windows, and which received bits form the result. Those scenarios also show the stall at the first zero byte under back-pressure and the refusal path of an instance with an illegal divider.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP
  } link_state_t;

  // Role of the byte currently on the wire
  typedef enum logic [1:0] {
    BK_CMD,
    BK_PAD1,
    BK_PAD2
  } byte_kind_t;

  // Command byte: start, select, unipolar flag, single-ended flag, clock/power bits
  function automatic logic [BYTE_W-1:0] make_cmd(input logic [2:0] sel,
                                                 input logic       bipolar,
                                                 input logic       single);
    make_cmd = {1'b1, sel, ~bipolar, single, 2'b11};
  endfunction

endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
  parameter int unsigned HALF_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);

  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int unsigned RES_W = 8,
  parameter int unsigned LEAD  = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           bip_i,
  input  logic           rise_i,
  input  logic           miso_i,
  output logic           done_o,
  output logic [RES_W:0] data_o
);

  localparam int unsigned FIRST = LEAD + 1;
  localparam int unsigned LAST  = LEAD + RES_W;
  localparam int unsigned CW    = $clog2(LAST + 1);

  logic             act_q;
  logic             bip_q;
  logic [CW-1:0]    pos_q;
  logic [RES_W-1:0] sh_q;
  logic [CW-1:0]    pos_n;
  logic             in_win;

  assign pos_n  = pos_q + 1'b1;
  assign in_win = (pos_n >= CW'(FIRST)) && (pos_n <= CW'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      bip_q  <= 1'b0;
      pos_q  <= '0;
      sh_q   <= '0;
      done_o <= 1'b0;
      data_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        act_q <= 1'b1;
        bip_q <= bip_i;
        pos_q <= '0;
      end else if (act_q && rise_i) begin
        pos_q <= pos_n;
        if (in_win) begin
          sh_q <= {sh_q[RES_W-2:0], miso_i};
        end
        if (pos_n == CW'(LAST)) begin
          act_q  <= 1'b0;
          done_o <= 1'b1;
          data_o <= {bip_q & sh_q[RES_W-2], sh_q[RES_W-2:0], miso_i};
        end
      end
    end
  end

endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned SYS_HZ     = 50_000_000,
  parameter int unsigned HALF_DIV   = 50,
  parameter int unsigned GAP_CYCLES = 16,
  parameter int unsigned RES_W      = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic [2:0]     req_sel_i,
  input  logic           req_bipolar_i,
  input  logic           req_single_i,
  input  logic           req_cont_i,
  output logic           res_valid_o,
  input  logic           res_ready_i,
  output logic [RES_W:0] res_data_o,
  output logic           err_o,
  output logic           cs_no,
  output logic           sclk_o,
  output logic           mosi_o,
  input  logic           miso_i
);

  // Timing legality, fixed at elaboration
  localparam int unsigned SCLK_PER = 2 * HALF_DIV;
  localparam int unsigned MIN_PER  = SYS_HZ / 500_000;
  localparam int unsigned MAX_PER  = SYS_HZ / 50_000;
  localparam int unsigned TXN_CYC  = 3 * BYTE_W * SCLK_PER + 2 * (GAP_CYCLES + 1);
  localparam int unsigned BUDGET   = SYS_HZ / 1000;
  localparam bit CFG_OK = (SCLK_PER >= MIN_PER) && (SCLK_PER <= MAX_PER) && (TXN_CYC <= BUDGET);
  localparam int unsigned GCW = $clog2(GAP_CYCLES + 2);
  localparam int unsigned BCW = $clog2(BYTE_W);

  link_state_t       state_q;
  byte_kind_t        kind_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BCW-1:0]    bit_q;
  logic [GCW-1:0]    gap_q;
  logic              cont_q, bip_q, sclk_q, cs_q, err_q;
  logic              res_valid_q;
  logic [RES_W:0]    res_q;

  logic tick, rise, fall, last_fall, cap_start, cap_done;
  logic gap_full, hold_res, gap_done, idle_take, cont_take, accept;
  logic [RES_W:0] cap_data;

  adc_rd_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q == ST_SHIFT),
    .tick_o(tick)
  );

  assign rise      = tick && !sclk_q;
  assign fall      = tick && sclk_q;
  assign last_fall = fall && (bit_q == BCW'(BYTE_W - 1));
  assign cap_start = last_fall && (kind_q == BK_CMD);

  adc_rd_capture #(.RES_W(RES_W), .LEAD(2)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(cap_start),
    .bip_i  (bip_q),
    .rise_i (rise),
    .miso_i (miso_i),
    .done_o (cap_done),
    .data_o (cap_data)
  );

  // The byte after the first pad completes a result: wait for an empty output first
  assign gap_full  = (gap_q == GCW'(GAP_CYCLES));
  assign hold_res  = (kind_q == BK_PAD1) && res_valid_q;
  assign gap_done  = (state_q == ST_GAP) && gap_full && !hold_res;
  assign idle_take = (state_q == ST_IDLE) && !res_valid_q;
  assign cont_take = gap_done && (kind_q == BK_PAD1) && cont_q;
  assign req_ready_o = idle_take || cont_take;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= BK_CMD;
      tx_q    <= '0;
      bit_q   <= '0;
      gap_q   <= '0;
      cont_q  <= 1'b0;
      bip_q   <= 1'b0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (CFG_OK) begin
              cs_q    <= 1'b0;
              tx_q    <= make_cmd(req_sel_i, req_bipolar_i, req_single_i);
              kind_q  <= BK_CMD;
              cont_q  <= req_cont_i;
              bip_q   <= req_bipolar_i;
              bit_q   <= '0;
              state_q <= ST_SHIFT;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (rise) begin
            sclk_q <= 1'b1;
          end else if (fall) begin
            sclk_q <= 1'b0;
            tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
            if (last_fall) begin
              bit_q   <= '0;
              gap_q   <= '0;
              state_q <= ST_GAP;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (!gap_full) begin
            gap_q <= gap_q + 1'b1;
          end else if (gap_done) begin
            unique case (kind_q)
              BK_CMD: begin
                tx_q    <= '0;
                kind_q  <= BK_PAD1;
                state_q <= ST_SHIFT;
              end
              BK_PAD1: begin
                state_q <= ST_SHIFT;
                if (accept) begin
                  tx_q   <= make_cmd(req_sel_i, req_bipolar_i, req_single_i);
                  kind_q <= BK_CMD;
                  cont_q <= req_cont_i;
                  bip_q  <= req_bipolar_i;
                end else begin
                  tx_q   <= '0;
                  kind_q <= BK_PAD2;
                end
              end
              default: begin
                cs_q    <= 1'b1;
                state_q <= ST_IDLE;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_q       <= '0;
    end else if (cap_done) begin
      res_valid_q <= 1'b1;
      res_q       <= cap_data;
    end else if (res_ready_i) begin
      res_valid_q <= 1'b0;
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_data_o  = res_q;
  assign err_o       = err_q;
  assign cs_no       = cs_q;
  assign sclk_o      = sclk_q;
  assign mosi_o      = tx_q[BYTE_W-1];

endmodule

// File: rtl/adc_readout_ctrl_chk.sv
module adc_readout_ctrl_chk #(
  parameter int unsigned HALF_DIV = 50,
  parameter int unsigned RES_W    = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_ready_o,
  input logic           res_valid_o,
  input logic           res_ready_i,
  input logic [RES_W:0] res_data_o,
  input logic           err_o,
  input logic           cs_no,
  input logic           sclk_o,
  input logic           mosi_o
);

  logic [15:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt_q <= '0;
    else if (sclk_o) hi_cnt_q <= hi_cnt_q + 1'b1;
    else hi_cnt_q <= '0;
  end

  AST_SCLK_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R3

  AST_MOSI_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o && $past(sclk_o) |-> $stable(mosi_o)); // R3

  AST_HIGH_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (hi_cnt_q == 16'(HALF_DIV))); // R9

  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_data_o)); // R7

  AST_SIGN_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_data_o[RES_W-1] |-> !res_data_o[RES_W]); // R6

  AST_ERR_NO_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> cs_no); // R10

  AST_READY_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !sclk_o && !res_valid_o); // R11

endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk #(
  .HALF_DIV(HALF_DIV),
  .RES_W   (RES_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .res_valid_o(res_valid_o),
  .res_ready_i(res_ready_i),
  .res_data_o (res_data_o),
  .err_o      (err_o),
  .cs_no      (cs_no),
  .sclk_o     (sclk_o),
  .mosi_o     (mosi_o)
);

// File: tb/test_adc_readout_ctrl.sv
module test_adc_readout_ctrl;

  localparam int HD  = 50;
  localparam int GAP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       req_valid = 1'b0, req_ready;
  logic [2:0] req_sel = '0;
  logic       req_bip = 1'b0, req_sgl = 1'b0, req_cont = 1'b0;
  logic       res_valid, res_ready = 1'b1;
  logic [8:0] res_data;
  logic       err, cs_n, sclk, mosi;
  logic       miso = 1'b0;

  adc_readout_ctrl #(.SYS_HZ(50_000_000), .HALF_DIV(HD), .GAP_CYCLES(GAP), .RES_W(8)) i_adc_readout_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_sel_i(req_sel),
    .req_bipolar_i(req_bip), .req_single_i(req_sgl), .req_cont_i(req_cont),
    .res_valid_o(res_valid), .res_ready_i(res_ready), .res_data_o(res_data),
    .err_o(err), .cs_no(cs_n), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso));

  // Second instance with a serial clock that is too fast
  logic       b_valid = 1'b0, b_ready, b_res_valid, b_err, b_cs, b_sclk, b_mosi;
  logic [8:0] b_res_data;
  adc_readout_ctrl #(.SYS_HZ(50_000_000), .HALF_DIV(10), .GAP_CYCLES(GAP), .RES_W(8)) i_bad (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(b_valid), .req_ready_o(b_ready), .req_sel_i(3'b000),
    .req_bipolar_i(1'b0), .req_single_i(1'b1), .req_cont_i(1'b0),
    .res_valid_o(b_res_valid), .res_ready_i(1'b1), .res_data_o(b_res_data),
    .err_o(b_err), .cs_no(b_cs), .sclk_o(b_sclk), .mosi_o(b_mosi), .miso_i(1'b0));

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  bit         force_en = 1'b0;
  logic [7:0] force_val = '0;
  logic [7:0] sl_in, sl_val;
  int         sl_nin, sl_r, sl_rises = 0, sl_frames = 0, n_cmd = 0;
  bit         sl_rx, sl_act;
  logic [63:0] sl_mosi = '0;
  logic [7:0] cmd_log [16];
  logic       prev_cs = 1'b1, prev_sclk = 1'b0;

  function automatic logic [7:0] conv_value(input logic [7:0] cmd);
    return force_en ? force_val : (cmd ^ 8'h3C);
  endfunction

  always @(cs_n or sclk) begin
    if (!cs_n && prev_cs) begin
      sl_rx = 0; sl_act = 0; sl_rises = 0; sl_frames++; miso = 1'b0;
    end else if (!cs_n && sclk && !prev_sclk) begin
      sl_rises++;
      sl_mosi = {sl_mosi[62:0], mosi};
      if (sl_act) begin
        sl_r++;
        if (sl_r >= 10) sl_act = 0;
      end
      if (!sl_rx) begin
        if (mosi) begin sl_rx = 1; sl_in = 8'h01; sl_nin = 1; end
      end else begin
        sl_in = {sl_in[6:0], mosi};
        sl_nin++;
        if (sl_nin == 8) begin
          sl_rx = 0;
          cmd_log[n_cmd % 16] = sl_in;
          n_cmd++;
          sl_val = conv_value(sl_in);
          sl_act = 1; sl_r = 0;
        end
      end
    end else if (!sclk && prev_sclk) begin
      if (sl_act && (sl_r + 1 >= 3) && (sl_r + 1 <= 10)) miso = sl_val[10 - (sl_r + 1)];
      else miso = 1'b0;
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  // ---------------- monitors ----------------
  logic [8:0] res_log [16];
  int n_res = 0, hi_run = 0, hi_bad = 0, hi_seen = 0, park_bad = 0;

  always @(negedge clk) begin
    if (res_valid && res_ready) begin
      res_log[n_res % 16] = res_data;
      n_res++;
    end
    if (cs_n && sclk) park_bad++;
    if (sclk) hi_run++;
    else if (hi_run != 0) begin
      hi_seen++;
      if (hi_run != HD) hi_bad++;
      hi_run = 0;
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [7:0] exp_cmd(input logic [2:0] s, input logic b, input logic g);
    return {1'b1, s, ~b, g, 2'b11};   // R2 layout
  endfunction

  function automatic logic [8:0] exp_res(input logic [7:0] v, input logic b);
    return {b & v[7], v};
  endfunction

  task automatic send_req(input logic [2:0] s, input logic b, input logic g, input logic c);
    @(negedge clk);
    req_sel = s; req_bip = b; req_sgl = g; req_cont = c; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_link_idle();
    while (!cs_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // sel[15:13] bip[12] sgl[11] force[10] pad[9:8] value[7:0]
  localparam logic [15:0] VEC [7] = '{
    {3'b111, 1'b0, 1'b1, 1'b0, 2'b00, 8'h00},
    {3'b000, 1'b1, 1'b0, 1'b1, 2'b00, 8'h80},
    {3'b010, 1'b0, 1'b1, 1'b1, 2'b00, 8'h80},
    {3'b101, 1'b1, 1'b1, 1'b1, 2'b00, 8'h7F},
    {3'b011, 1'b0, 1'b0, 1'b1, 2'b00, 8'h00},
    {3'b110, 1'b1, 1'b1, 1'b1, 2'b00, 8'hFF},
    {3'b001, 1'b0, 1'b1, 1'b1, 2'b00, 8'h01}
  };

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] c, v;
    logic [8:0] e;
    int n0, f0, k0;

    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs idle in reset", cs_n, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs high after reset", cs_n, 1);
    chk(sclk == 1'b0, "R1 sclk low after reset", sclk, 0);
    chk(res_valid == 1'b0, "R1 no result after reset", res_valid, 0);
    chk(err == 1'b0, "R1 no error after reset", err, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    // Vector table: single conversions
    for (int i = 0; i < 7; i++) begin
      force_en  = VEC[i][10];
      force_val = VEC[i][7:0];
      n0 = n_res; f0 = sl_frames;
      c = exp_cmd(VEC[i][15:13], VEC[i][12], VEC[i][11]);
      v = conv_value(c);
      e = exp_res(v, VEC[i][12]);
      send_req(VEC[i][15:13], VEC[i][12], VEC[i][11], 1'b0);
      while (n_res == n0) @(negedge clk);
      wait_link_idle();
      chk(res_log[n0 % 16] == e, "R5 R6 result value", res_log[n0 % 16], e);
      chk(cmd_log[(n_cmd - 1) % 16] == c, "R2 command byte", cmd_log[(n_cmd - 1) % 16], c);
      chk(sl_rises == 24, "R4 rising edges per transaction", sl_rises, 24);
      chk(sl_mosi[15:0] == 16'h0, "R4 pad bytes are zero", sl_mosi[15:0], 0);
      chk(sl_frames == f0 + 1, "R4 one chip-select window", sl_frames, f0 + 1);
    end

    // Back-pressure on a single conversion
    force_en = 1'b1; force_val = 8'hA6;
    res_ready = 1'b0;
    send_req(3'b100, 1'b1, 1'b1, 1'b0);
    while (!res_valid) @(negedge clk);
    repeat (300) @(negedge clk);
    chk(res_valid == 1'b1, "R7 result held", res_valid, 1);
    chk(res_data == 9'h1A6, "R7 R6 held data", res_data, 9'h1A6);
    chk(req_ready == 1'b0, "R11 no accept while result unread", req_ready, 0);
    n0 = n_res;
    res_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 result released", res_valid, 0);
    wait_link_idle();

    // Continuous chain of three conversions
    force_en = 1'b0;
    n0 = n_res; f0 = sl_frames; k0 = n_cmd;
    send_req(3'b001, 1'b0, 1'b1, 1'b1);
    send_req(3'b110, 1'b1, 1'b0, 1'b1);
    send_req(3'b011, 1'b1, 1'b1, 1'b0);
    while (n_res < n0 + 3) @(negedge clk);
    wait_link_idle();
    chk(sl_frames == f0 + 1, "R8 one window for chain", sl_frames, f0 + 1);
    chk(sl_rises == 56, "R8 rising edges for three chained", sl_rises, 56);
    chk(n_cmd == k0 + 3, "R8 three command bytes", n_cmd, k0 + 3);
    c = exp_cmd(3'b001, 1'b0, 1'b1);
    e = exp_res(conv_value(c), 1'b0);
    chk(res_log[n0 % 16] == e, "R8 first chained result", res_log[n0 % 16], e);
    c = exp_cmd(3'b110, 1'b1, 1'b0);
    chk(cmd_log[(k0 + 1) % 16] == c, "R8 R2 second command", cmd_log[(k0 + 1) % 16], c);
    e = exp_res(conv_value(c), 1'b1);
    chk(res_log[(n0 + 1) % 16] == e, "R8 second chained result", res_log[(n0 + 1) % 16], e);
    c = exp_cmd(3'b011, 1'b1, 1'b1);
    e = exp_res(conv_value(c), 1'b1);
    chk(res_log[(n0 + 2) % 16] == e, "R8 third chained result", res_log[(n0 + 2) % 16], e);

    // Chain under back-pressure: link must stall, not overwrite
    n0 = n_res; f0 = sl_frames;
    res_ready = 1'b0;
    send_req(3'b010, 1'b0, 1'b1, 1'b1);
    send_req(3'b101, 1'b0, 1'b0, 1'b0);
    while (!res_valid) @(negedge clk);
    repeat (3000) @(negedge clk);
    c = exp_cmd(3'b010, 1'b0, 1'b1);
    e = exp_res(conv_value(c), 1'b0);
    chk(res_data == e, "R7 first result kept during stall", res_data, e);
    chk(cs_n == 1'b0, "R7 window stays open during stall", cs_n, 0);
    chk(sclk == 1'b0, "R7 clock parked during stall", sclk, 0);
    res_ready = 1'b1;
    while (n_res < n0 + 2) @(negedge clk);
    wait_link_idle();
    chk(res_log[n0 % 16] == e, "R7 first stalled result", res_log[n0 % 16], e);
    c = exp_cmd(3'b101, 1'b0, 1'b0);
    e = exp_res(conv_value(c), 1'b0);
    chk(res_log[(n0 + 1) % 16] == e, "R7 R8 second stalled result", res_log[(n0 + 1) % 16], e);
    chk(sl_rises == 40, "R8 edges for two chained", sl_rises, 40);
    chk(sl_frames == f0 + 1, "R8 one window under stall", sl_frames, f0 + 1);

    // Illegal divider instance
    @(negedge clk);
    b_valid = 1'b1;
    chk(b_ready == 1'b1, "R10 illegal instance accepts", b_ready, 1);
    @(negedge clk);
    b_valid = 1'b0;
    chk(b_err == 1'b1, "R10 error pulse", b_err, 1);
    @(negedge clk);
    chk(b_err == 1'b0, "R10 error lasts one cycle", b_err, 0);
    begin
      int bad_cs = 0, bad_res = 0;
      for (int t = 0; t < 300; t++) begin
        @(negedge clk);
        if (!b_cs) bad_cs++;
        if (b_res_valid) bad_res++;
      end
      chk(bad_cs == 0, "R10 chip select stays high", bad_cs, 0);
      chk(bad_res == 0, "R10 no result produced", bad_res, 0);
    end

    chk(park_bad == 0, "R3 clock parked while deselected", park_bad, 0);
    chk(hi_seen > 0 && hi_bad == 0, "R9 high phase length", hi_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule